// File: doc/BRIEF.md
# Dual-Sided Inter-Processor Messaging Unit

This block lets two processor domains, side A and side B, pass 32-bit words to each other. Each side has its own simple register port with write enable, read enable, byte address and data. There are four channels in each direction. A word written into a side's transmit slot for channel n shows up in the other side's receive slot n. A handshake flag pair tracks whether that slot is occupied.

Each side can see per-channel "transmit slot free" and "receive slot holds a word" flags in its status word. It has matching enable bits in its control word. Any flag that is set while its enable is also set raises that side's single interrupt line. Software sends a word once the transmit-free flag is set. It collects a word by reading the receive slot, and that read frees the channel for the sender.

Read data is combinational from the address. Side effects (slot fill, slot drain, control update) take place at the rising clock edge while the enable is held.

Top module: `msgu_top`

## Requirements
- R1: Word address decode on each side (bits [5:2] of the byte address): transmit slot n at byte offset 4·n, receive slot n at 0x10 + 4·n, status at 0x20, control at 0x24. A word written to transmit slot n on one side is the value read from receive slot n on the other side.
- R2: In the status word, the transmit-free flag for channel n is at bit 20 + (3 − n) and the receive-full flag for channel n is at bit 24 + (3 − n).
- R3: A write to transmit slot n while its free flag is set clears the writer's free flag n and sets the partner's receive-full flag n from the next cycle.
- R4: A write-enabled or read-enabled access to receive slot n with rd_en high clears the reader's receive-full flag n and sets the partner's transmit-free flag n from the next cycle.
- R5: A write to transmit slot n while its free flag is clear is dropped, and the word already pending is delivered unchanged.
- R6: After reset, status reads 0x00F00000 on both sides (all free flags 1, all full flags 0), control reads 0, and both interrupts are low.
- R7: Control enables sit at the same bit positions as the flags they gate: transmit enable n at bit 20 + (3 − n), receive enable n at bit 24 + (3 − n). All other control bits read 0 whatever was written.
- R8: A side's interrupt is high exactly while some status flag and its matching enable are both set. All channels share the line.
- R9: Writes to the status word change nothing. Addresses above 0x24 read 0.
- R10: Channels and directions are independent: both sides may load the same channel in the same cycle, and each receives the other's word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both sides |
| rst | input | 1 | Synchronous active-high reset |
| a_wr_en | input | 1 | Side A write strobe |
| a_rd_en | input | 1 | Side A read strobe (drains receive slots) |
| a_addr | input | 6 | Side A byte address |
| a_wdata | input | 32 | Side A write data |
| a_rdata | output | 32 | Side A read data |
| a_irq | output | 1 | Side A interrupt |
| b_wr_en | input | 1 | Side B write strobe |
| b_rd_en | input | 1 | Side B read strobe (drains receive slots) |
| b_addr | input | 6 | Side B byte address |
| b_wdata | input | 32 | Side B write data |
| b_rdata | output | 32 | Side B read data |
| b_irq | output | 1 | Side B interrupt |

## Verification
On every cycle the assertions check three slot behaviours: an accepted push fills the slot with the pushed word, a push into an occupied slot leaves the word and the full state untouched, and a drain empties a full slot. They also check that control writes keep only the enable positions and that the interrupt stays low while nothing is enabled. The bench scenarios are what show the address map and the reversed flag bit order seen from both sides. They also show the cross-side handshake from write to read, the reset values, the interrupt rising and falling as flags move, and two sides loading the same channel at once.

// File: rtl/msgu_pkg.sv
`timescale 1ns/1ps
package msgu_pkg;
    localparam int NCH     = 4;
    localparam int DW      = 32;
    localparam int AW      = 6;
    localparam int WW      = AW - 2;
    localparam int CW      = $clog2(NCH);
    localparam int TE_BASE = 20;
    localparam int RF_BASE = 24;

    localparam logic [WW-1:0] W_RX0  = WW'(NCH);
    localparam logic [WW-1:0] W_STAT = WW'(2 * NCH);
    localparam logic [WW-1:0] W_CTRL = WW'(2 * NCH + 1);

    typedef enum logic [2:0] {
        ACC_NONE,
        ACC_TX,
        ACC_RX,
        ACC_STAT,
        ACC_CTRL
    } acc_kind_e;

    typedef struct packed {
        acc_kind_e       kind;
        logic [CW-1:0]   ch;
    } acc_t;

    function automatic int te_pos(input int n);
        return TE_BASE + (NCH - 1 - n);
    endfunction

    function automatic int rf_pos(input int n);
        return RF_BASE + (NCH - 1 - n);
    endfunction

    function automatic logic [DW-1:0] en_mask();
        logic [DW-1:0] m;
        m = '0;
        for (int n = 0; n < NCH; n++) begin
            m[te_pos(n)] = 1'b1;
            m[rf_pos(n)] = 1'b1;
        end
        return m;
    endfunction

    function automatic acc_t decode(input logic [AW-1:0] a);
        acc_t r;
        logic [WW-1:0] w;
        w = a[AW-1:2];
        r.ch = '0;
        if (w < W_RX0) begin
            r.kind = ACC_TX;
            r.ch   = CW'(w);
        end else if (w < W_STAT) begin
            r.kind = ACC_RX;
            r.ch   = CW'(w - W_RX0);
        end else if (w == W_STAT) begin
            r.kind = ACC_STAT;
        end else if (w == W_CTRL) begin
            r.kind = ACC_CTRL;
        end else begin
            r.kind = ACC_NONE;
        end
        return r;
    endfunction
endpackage

// File: rtl/msgu_lane.sv
`timescale 1ns/1ps
module msgu_lane
    import msgu_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic          pop,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] data,
    output logic          full
);
    always_ff @(posedge clk) begin
        if (rst) begin
            full <= 1'b0;
            data <= '0;
        end else if (push && !full) begin
            data <= wdata;
            full <= 1'b1;
        end else if (pop && full) begin
            full <= 1'b0;
        end
    end

    // R3: an accepted push fills the slot with the pushed word
    a_r3_push_fills: assert property (@(posedge clk) disable iff (rst)
        push && !full |=> full && data == $past(wdata));

    // R5: a push into an occupied slot changes nothing
    a_r5_drop_keeps_word: assert property (@(posedge clk) disable iff (rst)
        push && full && !pop |=> full && $stable(data));

    // R4: a drain empties a full slot
    a_r4_pop_empties: assert property (@(posedge clk) disable iff (rst)
        pop && full |=> !full);
endmodule

// File: rtl/msgu_port.sv
`timescale 1ns/1ps
module msgu_port
    import msgu_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   wr_en,
    input  logic                   rd_en,
    input  logic [AW-1:0]          addr,
    input  logic [DW-1:0]          wdata,
    input  logic [NCH-1:0]         tx_full,
    input  logic [NCH-1:0]         rx_full,
    input  logic [NCH-1:0][DW-1:0] rx_data,
    output logic [NCH-1:0]         tx_push,
    output logic [NCH-1:0]         rx_pop,
    output logic [DW-1:0]          rdata,
    output logic                   irq
);
    localparam logic [DW-1:0] EN_MASK = en_mask();

    acc_t          acc;
    logic [DW-1:0] stat;
    logic [DW-1:0] ctrl_q;

    assign acc = decode(addr);

    always_comb begin
        stat = '0;
        for (int n = 0; n < NCH; n++) begin
            stat[te_pos(n)] = ~tx_full[n];
            stat[rf_pos(n)] = rx_full[n];
        end
    end

    always_comb begin
        for (int n = 0; n < NCH; n++) begin
            tx_push[n] = wr_en && acc.kind == ACC_TX && acc.ch == CW'(n);
            rx_pop[n]  = rd_en && acc.kind == ACC_RX && acc.ch == CW'(n);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (wr_en && acc.kind == ACC_CTRL) begin
            ctrl_q <= wdata & EN_MASK;
        end
    end

    always_comb begin
        case (acc.kind)
            ACC_RX:   rdata = rx_data[acc.ch];
            ACC_STAT: rdata = stat;
            ACC_CTRL: rdata = ctrl_q;
            default:  rdata = '0;
        endcase
    end

    assign irq = |(stat & ctrl_q);

    // R7: control keeps only enable positions
    a_r7_ctrl_masked: assert property (@(posedge clk) disable iff (rst)
        wr_en && acc.kind == ACC_CTRL |=> ctrl_q == ($past(wdata) & EN_MASK));

    // R8: no enable, no interrupt
    a_r8_quiet_when_disabled: assert property (@(posedge clk) disable iff (rst)
        ctrl_q == '0 |-> !irq);
endmodule

// File: rtl/msgu_top.sv
`timescale 1ns/1ps
module msgu_top
    import msgu_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          a_wr_en,
    input  logic          a_rd_en,
    input  logic [AW-1:0] a_addr,
    input  logic [DW-1:0] a_wdata,
    output logic [DW-1:0] a_rdata,
    output logic          a_irq,
    input  logic          b_wr_en,
    input  logic          b_rd_en,
    input  logic [AW-1:0] b_addr,
    input  logic [DW-1:0] b_wdata,
    output logic [DW-1:0] b_rdata,
    output logic          b_irq
);
    logic [NCH-1:0]         ab_full, ba_full;
    logic [NCH-1:0][DW-1:0] ab_data, ba_data;
    logic [NCH-1:0]         a_push, a_pop, b_push, b_pop;

    for (genvar n = 0; n < NCH; n++) begin : g_ch
        msgu_lane u_ab (
            .clk   (clk),
            .rst   (rst),
            .push  (a_push[n]),
            .pop   (b_pop[n]),
            .wdata (a_wdata),
            .data  (ab_data[n]),
            .full  (ab_full[n])
        );
        msgu_lane u_ba (
            .clk   (clk),
            .rst   (rst),
            .push  (b_push[n]),
            .pop   (a_pop[n]),
            .wdata (b_wdata),
            .data  (ba_data[n]),
            .full  (ba_full[n])
        );
    end

    msgu_port u_port_a (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (a_wr_en),
        .rd_en   (a_rd_en),
        .addr    (a_addr),
        .wdata   (a_wdata),
        .tx_full (ab_full),
        .rx_full (ba_full),
        .rx_data (ba_data),
        .tx_push (a_push),
        .rx_pop  (a_pop),
        .rdata   (a_rdata),
        .irq     (a_irq)
    );

    msgu_port u_port_b (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (b_wr_en),
        .rd_en   (b_rd_en),
        .addr    (b_addr),
        .wdata   (b_wdata),
        .tx_full (ba_full),
        .rx_full (ab_full),
        .rx_data (ab_data),
        .tx_push (b_push),
        .rx_pop  (b_pop),
        .rdata   (b_rdata),
        .irq     (b_irq)
    );
endmodule

// File: tb/msgu_top_tb.sv
`timescale 1ns/1ps
module msgu_top_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        a_wr_en = 0, a_rd_en = 0, b_wr_en = 0, b_rd_en = 0;
    logic [5:0]  a_addr = 0, b_addr = 0;
    logic [31:0] a_wdata = 0, b_wdata = 0;
    logic [31:0] a_rdata, b_rdata;
    logic        a_irq, b_irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    localparam logic [31:0] IDLE_STAT = 32'h00F0_0000;

    always #5 clk = ~clk;

    msgu_top u_dut (
        .clk(clk), .rst(rst),
        .a_wr_en(a_wr_en), .a_rd_en(a_rd_en), .a_addr(a_addr), .a_wdata(a_wdata),
        .a_rdata(a_rdata), .a_irq(a_irq),
        .b_wr_en(b_wr_en), .b_rd_en(b_rd_en), .b_addr(b_addr), .b_wdata(b_wdata),
        .b_rdata(b_rdata), .b_irq(b_irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input bit side, input logic [5:0] ad, input logic [31:0] d);
        @(negedge clk);
        if (side == 0) begin a_wr_en = 1; a_addr = ad; a_wdata = d; end
        else           begin b_wr_en = 1; b_addr = ad; b_wdata = d; end
        @(negedge clk);
        a_wr_en = 0; b_wr_en = 0;
    endtask

    task automatic rd(input bit side, input logic [5:0] ad, output logic [31:0] d);
        @(negedge clk);
        if (side == 0) begin a_rd_en = 1; a_addr = ad; end
        else           begin b_rd_en = 1; b_addr = ad; end
        #1;
        d = (side == 0) ? a_rdata : b_rdata;
        @(negedge clk);
        a_rd_en = 0; b_rd_en = 0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(0, 6'h20, v); chk("R6 A status", v, IDLE_STAT);
        rd(1, 6'h20, v); chk("R6 B status", v, IDLE_STAT);
        rd(0, 6'h24, v); chk("R6 A ctrl", v, 0);
        rd(1, 6'h24, v); chk("R6 B ctrl", v, 0);
        chk("R6 irqs", {a_irq, b_irq}, 0);
    endtask

    task automatic t_a_to_b();
        logic [31:0] v;
        wr(0, 6'h00, 32'h1111_0000);
        rd(0, 6'h20, v); chk("R3 A free0 cleared", v, 32'h0070_0000);
        rd(1, 6'h20, v); chk("R2 R3 B full0 bit27", v, 32'h08F0_0000);
        rd(1, 6'h10, v); chk("R1 B rx0 data", v, 32'h1111_0000);
        rd(1, 6'h20, v); chk("R4 B full0 cleared", v, IDLE_STAT);
        rd(0, 6'h20, v); chk("R4 A free0 restored", v, IDLE_STAT);
    endtask

    task automatic t_b_to_a();
        logic [31:0] v;
        wr(1, 6'h0C, 32'h0000_CAFE);
        rd(1, 6'h20, v); chk("R2 B free3 bit20 cleared", v, 32'h00E0_0000);
        rd(0, 6'h20, v); chk("R2 A full3 bit24", v, 32'h01F0_0000);
        rd(0, 6'h1C, v); chk("R1 A rx3 data", v, 32'h0000_CAFE);
        rd(1, 6'h20, v); chk("R4 B free3 restored", v, IDLE_STAT);
    endtask

    task automatic t_overflow();
        logic [31:0] v;
        wr(0, 6'h04, 32'h0000_AAAA);
        wr(0, 6'h04, 32'h0000_BBBB);
        rd(0, 6'h20, v); chk("R5 A free1 still clear", v, 32'h00B0_0000);
        rd(1, 6'h14, v); chk("R5 pending word kept", v, 32'h0000_AAAA);
        rd(1, 6'h20, v); chk("R5 B slot drained", v, IDLE_STAT);
    endtask

    task automatic t_irq();
        logic [31:0] v;
        wr(0, 6'h24, 32'hFFFF_FFFF);
        rd(0, 6'h24, v); chk("R7 ctrl reserved bits zero", v, 32'h0FF0_0000);
        chk("R8 A irq all enabled", a_irq, 1);
        wr(0, 6'h24, 32'h0020_0000);
        chk("R8 A irq free2 enabled", a_irq, 1);
        wr(0, 6'h08, 32'h0000_2222);
        chk("R8 A irq drops when free2 clears", a_irq, 0);
        wr(1, 6'h24, 32'h0200_0000);
        chk("R8 B irq full2 enabled", b_irq, 1);
        rd(1, 6'h18, v); chk("R1 B rx2 data", v, 32'h0000_2222);
        chk("R8 B irq drops after drain", b_irq, 0);
        chk("R8 A irq returns", a_irq, 1);
        wr(0, 6'h24, 0);
        wr(1, 6'h24, 0);
        chk("R8 irqs off", {a_irq, b_irq}, 0);
    endtask

    task automatic t_ignored();
        logic [31:0] v;
        wr(0, 6'h20, 32'hFFFF_FFFF);
        rd(0, 6'h20, v); chk("R9 A status write ignored", v, IDLE_STAT);
        rd(1, 6'h20, v); chk("R9 B status unaffected", v, IDLE_STAT);
        rd(0, 6'h28, v); chk("R9 unused 0x28 reads zero", v, 0);
        rd(1, 6'h3C, v); chk("R9 unused 0x3C reads zero", v, 0);
    endtask

    task automatic t_both_ways();
        logic [31:0] v;
        @(negedge clk);
        a_wr_en = 1; a_addr = 6'h00; a_wdata = 32'hA0A0_0001;
        b_wr_en = 1; b_addr = 6'h00; b_wdata = 32'hB0B0_0002;
        @(negedge clk);
        a_wr_en = 0; b_wr_en = 0;
        rd(0, 6'h20, v); chk("R10 A free0 clear full0 set", v, 32'h0870_0000);
        rd(0, 6'h10, v); chk("R10 A got B word", v, 32'hB0B0_0002);
        rd(1, 6'h10, v); chk("R10 B got A word", v, 32'hA0A0_0001);
        rd(1, 6'h20, v); chk("R10 B idle", v, IDLE_STAT);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        t_reset();
        t_a_to_b();
        t_b_to_a();
        t_overflow();
        t_irq();
        t_ignored();
        t_both_ways();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule